// File: doc/BRIEF.md
# Inventory Anticollision Slot Matcher

This block decides whether, and in which time slot, a vicinity tag answers an inventory request. When the command decoder accepts an inventory request it pulses a start strobe. At that moment the block captures four request fields: the mask value, the mask length, the slot-count choice (sixteen slots or one) and the tag's eligibility. The tag is eligible when it is not in the quiet state and the request does not carry the application-family flag. The tag's 64-bit identifier is a static input.

For each slot, a guard timer counts the response delay. When the timer expires, the block compares the low bits of the identifier with a key. The key is the slot number placed directly above the low mask-length bits of the mask. In single-slot mode the key is the mask alone. On a match, the block issues a one-cycle respond request to the uplink encoder. Slot markers from the downlink decoder then advance the sequence. An end of frame moves to the next slot or closes the sequence. A start of frame aborts the sequence and returns control to normal command handling.

The guard timer restarts whenever a full-depth (100 %) modulation pause is seen while it runs. Timing is counted in ticks of `clk`, and `clk` is taken to be the carrier clock.

Top module: `inv_slot_matcher`

## Requirements
- R1: After reset `respond`, `handBack` and `active` are 0 and `slotNum` is 0.
- R2: A pulse on `invStart` sets the slot counter to 0, raises `active` on the next cycle and starts the guard timer for slot 0. This also applies when a sequence is already running.
- R3: The guard delay is `T1_CYC` cycles. The respond pulse is high in the cycle that follows the `T1_CYC`-th rising clock edge after the edge that sampled `invStart`, or after the edge that sampled the `eofSeen` which opened the slot.
- R4: A `fullPause` pulse while the guard timer runs reloads it. The respond pulse then comes `T1_CYC` edges after the edge that sampled the pause.
- R5: With `oneSlot` = 0 (sixteen slots) the tag matches in slot s when identifier bits [L+3:0] equal s in bits [L+3:L] and the mask in bits [L-1:0], where L is `maskLen`. Mask bits at L and above are ignored.
- R6: With `oneSlot` = 1 only identifier bits [L-1:0] are compared with the mask, and L = 0 always matches. The slot number stays 0, and the first `eofSeen` after the guard delay ends the sequence (`active` drops).
- R7: In sixteen-slot mode each `eofSeen` received after the guard delay has expired moves `slotNum` up by one while it is below 15. The `eofSeen` received in slot 15 ends the sequence.
- R8: A `sofSeen` pulse while `active` is 1 clears `active`, gives a one-cycle `handBack` pulse, and no respond pulse follows.
- R9: When `quiet` or `afiSet` is 1 at `invStart`, no respond pulse occurs in any slot of that sequence.
- R10: A mask length above 60 (sixteen slots) or above 64 (one slot) makes the whole sequence silent, although slots still advance.
- R11: The respond pulse lasts one cycle, at most one occurs per slot, and only in a slot whose key matches.
- R12: An `eofSeen` that arrives while the guard timer is still running is ignored: the slot number and the respond timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rstN | input | 1 | Active-low asynchronous reset |
| uid | input | 64 | Tag identifier, static |
| maskLen | input | 7 | Mask length in bits, sampled at `invStart` |
| maskVal | input | 64 | Mask value with zero padding, sampled at `invStart` |
| oneSlot | input | 1 | 1 = single slot, 0 = sixteen slots |
| quiet | input | 1 | Tag is in the quiet state |
| afiSet | input | 1 | Request carries the application-family flag |
| invStart | input | 1 | Pulse at the rising edge of the inventory request's end of frame |
| eofSeen | input | 1 | Pulse at the rising edge of a slot-marker end of frame |
| sofSeen | input | 1 | Pulse when a start of frame is decoded |
| fullPause | input | 1 | Pulse when a 100 % modulation pause is seen |
| respond | output | 1 | One-cycle request to send the inventory answer |
| active | output | 1 | Anticollision sequence in progress |
| slotNum | output | 4 | Current slot number |
| handBack | output | 1 | One-cycle pulse when a start of frame aborts the sequence |

## Verification
The assertions assume that the marker strobes are single-cycle pulses. They also assume that `uid` holds still during a sequence, and that a slot-advancing `eofSeen` comes only after the guard timer has expired. The bench drives every strobe as a one-cycle pulse at the falling edge and keeps `uid` fixed across each sequence. It sends slot markers only after waiting beyond the guard delay, except in the one deliberate case of an early end of frame. It sweeps mask lengths and masks against fixed identifiers. For every slot, the expected answer is built bit by bit from the identifier, the mask and the slot number.

// File: rtl/invslot_pkg.sv
package invslot_pkg;

  typedef struct packed {
    logic loadParams;
    logic incSlot;
    logic loadTimer;
    logic tickTimer;
  } ctrlStrobe_t;

  typedef struct packed {
    logic timerDone;
    logic matchHit;
    logic paramsOk;
    logic lastSlot;
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TIME = 2'd1,
    ST_WAIT = 2'd2
  } seqState_t;

endpackage

// File: rtl/invslot_dp.sv
module invslot_dp
  import invslot_pkg::*;
#(
  parameter int UID_W  = 64,
  parameter int SLOT_W = 4,
  parameter int T1_CYC = 4352,
  parameter int LEN_W  = $clog2(UID_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [UID_W-1:0]  uid,
  input  logic [LEN_W-1:0]  maskLen,
  input  logic [UID_W-1:0]  maskVal,
  input  logic              oneSlot,
  input  logic              quiet,
  input  logic              afiSet,
  output dpStatus_t         status,
  output logic [SLOT_W-1:0] slotNum
);

  localparam int TMR_W    = (T1_CYC > 2) ? $clog2(T1_CYC) : 1;
  localparam int MAX_MULT = UID_W - SLOT_W;

  logic [UID_W-1:0]  maskL;
  logic [LEN_W-1:0]  lenL;
  logic              oneL;
  logic              okL;
  logic [SLOT_W-1:0] slotQ;
  logic [TMR_W-1:0]  tmrQ;

  logic              lenFits;
  int                cmpLen;
  logic [UID_W-1:0]  lenMask;
  logic [UID_W-1:0]  cmpMask;
  logic [UID_W-1:0]  keyV;

  always_comb begin
    if (oneSlot) lenFits = (int'(maskLen) <= UID_W);
    else         lenFits = (int'(maskLen) <= MAX_MULT);
  end

  // request capture and slot counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskL <= '0;
      lenL  <= '0;
      oneL  <= 1'b0;
      okL   <= 1'b0;
      slotQ <= '0;
    end else if (strobe.loadParams) begin
      maskL <= maskVal;
      lenL  <= maskLen;
      oneL  <= oneSlot;
      okL   <= !quiet && !afiSet && lenFits;
      slotQ <= '0;
    end else if (strobe.incSlot) begin
      slotQ <= slotQ + 1'b1;
    end
  end

  // guard timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 tmrQ <= '0;
    else if (strobe.loadTimer) tmrQ <= TMR_W'(T1_CYC - 1);
    else if (strobe.tickTimer) tmrQ <= tmrQ - 1'b1;
  end

  // thermometer masks for the mask field and the full compare window
  always_comb cmpLen = int'(lenL) + (oneL ? 0 : SLOT_W);

  for (genvar b = 0; b < UID_W; b++) begin : g_bit
    assign lenMask[b] = (b < int'(lenL));
    assign cmpMask[b] = (b < cmpLen);
  end

  always_comb begin
    keyV = maskL & lenMask;
    if (!oneL) keyV = keyV | (UID_W'(slotQ) << lenL);
  end

  assign status.matchHit  = (((uid ^ keyV) & cmpMask) == '0);
  assign status.paramsOk  = okL;
  assign status.timerDone = (tmrQ == '0);
  assign status.lastSlot  = oneL || (slotQ == {SLOT_W{1'b1}});
  assign slotNum          = slotQ;

  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotQ != $past(slotQ)) |-> (slotQ == $past(slotQ) + 1'b1 || slotQ == '0));

  // R6
  single_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    oneL |-> (slotQ == '0));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tickTimer |-> (tmrQ != '0));

  // R10
  len_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    okL |-> (int'(lenL) <= (oneL ? UID_W : MAX_MULT)));

endmodule

// File: rtl/invslot_ctrl.sv
module invslot_ctrl
  import invslot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        invStart,
  input  logic        eofSeen,
  input  logic        sofSeen,
  input  logic        fullPause,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        respond,
  output logic        active,
  output logic        handBack
);

  seqState_t state, nextState;
  logic      respondD;
  logic      handD;

  always_comb begin
    strobe    = '0;
    nextState = state;
    respondD  = 1'b0;
    handD     = 1'b0;
    if (invStart) begin
      strobe.loadParams = 1'b1;
      strobe.loadTimer  = 1'b1;
      nextState         = ST_TIME;
    end else if (sofSeen && state != ST_IDLE) begin
      nextState = ST_IDLE;
      handD     = 1'b1;
    end else begin
      unique case (state)
        ST_TIME: begin
          if (fullPause) begin
            strobe.loadTimer = 1'b1;
          end else if (status.timerDone) begin
            respondD  = status.matchHit && status.paramsOk;
            nextState = ST_WAIT;
          end else begin
            strobe.tickTimer = 1'b1;
          end
        end
        ST_WAIT: begin
          if (eofSeen) begin
            if (status.lastSlot) begin
              nextState = ST_IDLE;
            end else begin
              strobe.incSlot   = 1'b1;
              strobe.loadTimer = 1'b1;
              nextState        = ST_TIME;
            end
          end
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      respond  <= 1'b0;
      handBack <= 1'b0;
    end else begin
      state    <= nextState;
      respond  <= respondD;
      handBack <= handD;
    end
  end

  assign active = (state != ST_IDLE);

  // R11
  resp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    respond |=> !respond);

  // R9
  resp_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    respond |-> $past(status.paramsOk && status.matchHit));

  // R8
  hand_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    handBack |-> ($past(sofSeen) && !active && !respond));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    invStart |=> active);

  // R7
  seq_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && eofSeen && status.lastSlot && !invStart && !sofSeen)
      |=> !active);

endmodule

// File: rtl/inv_slot_matcher.sv
module inv_slot_matcher
  import invslot_pkg::*;
#(
  parameter int T1_CYC = 4352
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] uid,
  input  logic [6:0]  maskLen,
  input  logic [63:0] maskVal,
  input  logic        oneSlot,
  input  logic        quiet,
  input  logic        afiSet,
  input  logic        invStart,
  input  logic        eofSeen,
  input  logic        sofSeen,
  input  logic        fullPause,
  output logic        respond,
  output logic        active,
  output logic [3:0]  slotNum,
  output logic        handBack
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  invslot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .invStart  (invStart),
    .eofSeen   (eofSeen),
    .sofSeen   (sofSeen),
    .fullPause (fullPause),
    .status    (status),
    .strobe    (strobe),
    .respond   (respond),
    .active    (active),
    .handBack  (handBack)
  );

  invslot_dp #(
    .UID_W  (64),
    .SLOT_W (4),
    .T1_CYC (T1_CYC),
    .LEN_W  (7)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .uid     (uid),
    .maskLen (maskLen),
    .maskVal (maskVal),
    .oneSlot (oneSlot),
    .quiet   (quiet),
    .afiSet  (afiSet),
    .status  (status),
    .slotNum (slotNum)
  );

endmodule

// File: tb/test_inv_slot_matcher.sv
module test_inv_slot_matcher;

  localparam int T1 = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] uid = '0;
  logic [6:0]  maskLen = '0;
  logic [63:0] maskVal = '0;
  logic        oneSlot = 1'b0;
  logic        quiet = 1'b0;
  logic        afiSet = 1'b0;
  logic        invStart = 1'b0;
  logic        eofSeen = 1'b0;
  logic        sofSeen = 1'b0;
  logic        fullPause = 1'b0;
  logic        respond;
  logic        active;
  logic [3:0]  slotNum;
  logic        handBack;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  inv_slot_matcher #(.T1_CYC(T1)) i_inv_slot_matcher (
    .clk(clk), .rstN(rstN), .uid(uid), .maskLen(maskLen), .maskVal(maskVal),
    .oneSlot(oneSlot), .quiet(quiet), .afiSet(afiSet), .invStart(invStart),
    .eofSeen(eofSeen), .sofSeen(sofSeen), .fullPause(fullPause),
    .respond(respond), .active(active), .slotNum(slotNum), .handBack(handBack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  // 0 = invStart, 1 = eofSeen, 2 = sofSeen, 3 = fullPause
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: invStart = 1'b1;
      1: eofSeen = 1'b1;
      2: sofSeen = 1'b1;
      default: fullPause = 1'b1;
    endcase
    @(negedge clk);
    invStart = 1'b0; eofSeen = 1'b0; sofSeen = 1'b0; fullPause = 1'b0;
  endtask

  function automatic bit expMatch(input logic [63:0] u, input logic [63:0] m,
                                  input int len, input bit one, input int s);
    int span = one ? len : len + 4;
    for (int b = 0; b < span; b++) begin
      bit want = (b < len) ? m[b] : ((s >> (b - len)) & 1);
      if (u[b] != want) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic runSeq(input logic [63:0] u, input logic [63:0] m, input int len,
                        input bit one, input bit q, input bit a, input string req);
    bit ok = !q && !a && (len <= (one ? 64 : 60));
    int nSlots = one ? 1 : 16;
    @(negedge clk);
    uid = u; maskVal = m; maskLen = 7'(len); oneSlot = one; quiet = q; afiSet = a;
    pulse(0);
    for (int s = 0; s < nSlots; s++) begin
      int hits = 0;
      int hitAt = -1;
      bit expHit = ok && expMatch(u, m, len, one, s);
      for (int i = 1; i <= T1 + 2; i++) begin
        @(negedge clk);
        if (i == 1) chk(slotNum == 4'(s) && active, "R7 slot number", slotNum, s);
        if (respond) begin hits++; hitAt = i; end
      end
      if (expHit) chk(hits == 1 && hitAt == T1, {req, " R3 R11 hit"}, hitAt, T1);
      else        chk(hits == 0, {req, " R11 silent"}, hits, 0);
      pulse(1);
    end
    chk(!active, one ? "R6 end after one slot" : "R7 end after slot 15", active, 0);
  endtask

  initial begin
    logic [63:0] uA = 64'hE016_8A3C_1234_5A7C;
    logic [63:0] uB = 64'hE016_0F00_C3A5_9961;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!respond && !active && !handBack && slotNum == 0, "R1 reset", {respond, active, handBack}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!active && slotNum == 0, "R1 after release", active, 0);

    // R5 sixteen-slot sweep, matching and non-matching masks
    for (int len = 0; len <= 10; len++) begin
      runSeq(uA, uA, len, 1'b0, 1'b0, 1'b0, "R5 match");
      runSeq(uB, uB ^ 64'h1, len, 1'b0, 1'b0, 1'b0, "R5 flip");
    end
    // R5 padding above the mask length is ignored
    runSeq(uA, (uA & 64'hFF) | 64'hF0F0_0000_0000_0000, 8, 1'b0, 1'b0, 1'b0, "R5 padding");
    runSeq(uA, uA, 60, 1'b0, 1'b0, 1'b0, "R5 max length");
    // R10 over-long mask
    runSeq(uA, uA, 61, 1'b0, 1'b0, 1'b0, "R10 len 61 multi");
    runSeq(uA, uA, 65, 1'b1, 1'b0, 1'b0, "R10 len 65 single");
    // R6 single slot
    runSeq(uB, 64'h0, 0, 1'b1, 1'b0, 1'b0, "R6 len 0");
    runSeq(uB, uB, 5, 1'b1, 1'b0, 1'b0, "R6 len 5");
    runSeq(uB, uB ^ 64'h10, 5, 1'b1, 1'b0, 1'b0, "R6 len 5 miss");
    runSeq(uB, uB, 64, 1'b1, 1'b0, 1'b0, "R6 len 64");
    runSeq(uB, uB ^ (64'h1 << 63), 64, 1'b1, 1'b0, 1'b0, "R6 len 64 miss");
    // R9 quiet and application-family flag
    runSeq(uA, uA, 0, 1'b0, 1'b1, 1'b0, "R9 quiet");
    runSeq(uA, uA, 0, 1'b1, 1'b0, 1'b1, "R9 afi");

    // R4 pause restarts the guard timer
    begin
      int hitAt = -1;
      @(negedge clk);
      uid = uA; maskVal = '0; maskLen = '0; oneSlot = 1'b1; quiet = 1'b0; afiSet = 1'b0;
      pulse(0);
      for (int i = 1; i <= T1 + 10; i++) begin
        @(negedge clk);
        if (respond) hitAt = i;
        fullPause = (i == 5);
      end
      chk(hitAt == T1 + 6, "R4 pause restart", hitAt, T1 + 6);
      pulse(1);
      chk(!active, "R6 end after pause slot", active, 0);
    end

    // R12 early end of frame is ignored
    begin
      int hitAt = -1;
      @(negedge clk);
      uid = uA; maskVal = '0; maskLen = '0; oneSlot = 1'b1;
      pulse(0);
      for (int i = 1; i <= T1 + 2; i++) begin
        @(negedge clk);
        if (respond) hitAt = i;
        eofSeen = (i == 3);
      end
      chk(hitAt == T1, "R12 timing kept", hitAt, T1);
      chk(active && slotNum == 0, "R12 still in slot 0", slotNum, 0);
      pulse(1);
      chk(!active, "R12 real marker ends", active, 0);
    end

    // R8 start of frame aborts
    begin
      int hits = 0;
      @(negedge clk);
      uid = uA; maskVal = '0; maskLen = '0; oneSlot = 1'b1;
      pulse(0);
      pulse(2);
      chk(handBack && !active, "R8 abort hand back", {handBack, active}, 2);
      @(negedge clk);
      chk(!handBack, "R8 hand back one cycle", handBack, 0);
      for (int i = 1; i <= T1 + 4; i++) begin
        @(negedge clk);
        if (respond) hits++;
      end
      chk(hits == 0, "R8 no answer after abort", hits, 0);
    end

    // R2 restart during a running sequence
    begin
      @(negedge clk);
      uid = uA; maskVal = uA; maskLen = 7'd4; oneSlot = 1'b0;
      pulse(0);
      repeat (T1 + 2) @(negedge clk);
      pulse(1);
      @(negedge clk);
      chk(slotNum == 1, "R7 advanced", slotNum, 1);
      pulse(0);
      chk(slotNum == 0 && active, "R2 restart clears slot", slotNum, 0);
      pulse(2);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule